// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Unit

This unit tracks receive and transmit interrupt sources for a two-channel serial controller. For each channel it holds a pending flag and an in-service flag for the receive source and for the transmit source. From these it builds a shared interrupt-pending register and a modified vector that the host reads back to learn which source needs service. A receive source in service keeps the transmit source of the same channel from being vectored. The host releases it with a clear-in-service command, a data read or a clear-transmit command.

Channel events (receive character available, transmit buffer empty) and host commands arrive as one-cycle pulses, indexed with bit 0 for channel A and bit 1 for channel B. Several events in one cycle are handled in a fixed order: channel A before channel B, and within a channel the data read first, then clear-transmit, clear-in-service, receive raise and transmit raise. The vector register keeps the value written last. The combined interrupt line is combinational from the registered flags and the enable inputs.

Top module: `sio_irq_vector`

## Requirements
- R1: A synchronous reset clears all pending and in-service flags and sets `int_pend` to 0 and `irq` to 0. It loads `vector` with the no-interrupt code, which is 0x06 when `status_hi` is 0 and 0x60 when it is 1.
- R2: A receive event on a channel sets that channel's receive pending and in-service flags. It sets `int_pend` bit 5 for channel A or bit 2 for channel B, and always loads the receive code: A 0x0C or 0x30, B 0x04 or 0x20 (status_hi 0 or 1).
- R3: A transmit event with no receive in service on that channel loads the transmit code (A 0x08 or 0x10, B 0x00 in both modes) and marks transmit in service. It sets `int_pend` bit 4 for channel A or bit 1 for channel B only when that channel's `tx_int_en` is 1.
- R4: A transmit event while receive is in service on that channel sets transmit pending but leaves `vector` and `int_pend` unchanged.
- R5: Clear-in-service clears receive in-service if it is set and then vectors a pending transmit source as in R3. Otherwise it clears transmit in-service, with no change to `vector` or `int_pend`.
- R6: A data read clears receive pending, receive in-service and the receive bit of `int_pend`, and loads the no-interrupt code. If transmit is pending it then re-raises it as in R3.
- R7: Clear-transmit clears transmit pending, transmit in-service and the transmit bit of `int_pend`, and loads the no-interrupt code. If receive is pending it then re-raises it as in R2.
- R8: A channel requests an interrupt when transmit is pending and `tx_int_en` is 1, or when receive is pending and its mode field is 01 or 10 (00 and 11 give no receive request), or when `brk_int_en` and `brk_stat` are both 1.
- R9: `irq` is the OR of the two channels' requests, so either channel alone drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_hi | input | 1 | Selects the high-bit vector encoding |
| tx_int_en | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, [1:0] channel A, [3:2] channel B |
| brk_int_en | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| rx_char_ev | input | 2 | Receive character available pulse |
| tx_empty_ev | input | 2 | Transmit buffer empty pulse |
| data_rd | input | 2 | Host read of the data register |
| clr_tx_cmd | input | 2 | Clear transmit interrupt command |
| clr_ius_cmd | input | 2 | Clear highest in-service command |
| irq | output | 1 | Combined interrupt request |
| int_pend | output | 6 | Interrupt-pending register |
| vector | output | 8 | Modified interrupt vector |

## Verification
The same event script runs on each channel under both vector encodings, with transmit interrupts enabled and disabled. This separates the two encodings and shows whether a missing `int_pend` bit comes from the enable or from the blocking rule. The script raises receive and transmit together and checks that the receive code comes first and the transmit code follows the release. It then checks that each of the three release paths re-raises the other source. Separate patterns try all four receive modes and each break enable and status combination, and show that either channel alone raises the combined line.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int NCH    = 2;
    localparam int CH_A   = 0;
    localparam int MODE_W = 2;
    localparam int PEND_W = 6;
    localparam int VEC_W  = 8;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TX   = 2'd1,
        SRC_RX   = 2'd2
    } src_e;

    typedef struct packed {
        logic [NCH-1:0]    rx_pend;
        logic [NCH-1:0]    tx_pend;
        logic [NCH-1:0]    rx_ius;
        logic [NCH-1:0]    tx_ius;
        logic [PEND_W-1:0] ipend;
        logic [VEC_W-1:0]  vec;
    } irq_state_t;

    function automatic logic [VEC_W-1:0] vec_code(input src_e src,
                                                  input logic is_a,
                                                  input logic hi);
        logic [VEC_W-1:0] v;
        case (src)
            SRC_RX:  v = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            SRC_TX:  v = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction

    function automatic int pend_bit(input logic is_a, input logic is_rx);
        int base;
        base = is_a ? 3 : 0;
        return base + (is_rx ? 2 : 1);
    endfunction

endpackage

// File: rtl/sio_irq_cond.sv
module sio_irq_cond #(
    parameter int MODE_W = 2
) (
    input  logic              tx_en,
    input  logic              tx_pend,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic              rx_pend,
    input  logic              brk_en,
    input  logic              brk_stat,
    output logic              req
);
    logic rx_on;

    always_comb begin
        rx_on = (rx_mode == MODE_W'(1)) || (rx_mode == MODE_W'(2));
        req   = (tx_en && tx_pend) || (rx_on && rx_pend) || (brk_en && brk_stat);
    end

endmodule

// File: rtl/sio_irq_core.sv
module sio_irq_core
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              status_hi,
    input  logic [NCH-1:0]    tx_int_en,
    input  logic [NCH-1:0]    rx_ev,
    input  logic [NCH-1:0]    tx_ev,
    input  logic [NCH-1:0]    data_rd,
    input  logic [NCH-1:0]    clr_tx,
    input  logic [NCH-1:0]    clr_ius,
    output logic [NCH-1:0]    rx_pend,
    output logic [NCH-1:0]    tx_pend,
    output logic [PEND_W-1:0] int_pend,
    output logic [VEC_W-1:0]  vector
);
    irq_state_t st_q, st_d;

    function automatic irq_state_t raise_rx(input irq_state_t s, input int c, input logic hi);
        irq_state_t r;
        logic       a;
        r = s;
        a = (c == CH_A);
        r.rx_pend[c] = 1'b1;
        r.rx_ius[c]  = 1'b1;
        r.ipend[pend_bit(a, 1'b1)] = 1'b1;
        r.vec = vec_code(SRC_RX, a, hi);
        return r;
    endfunction

    function automatic irq_state_t raise_tx(input irq_state_t s, input int c,
                                            input logic hi, input logic en);
        irq_state_t r;
        logic       a;
        r = s;
        a = (c == CH_A);
        r.tx_pend[c] = 1'b1;
        if (!r.rx_ius[c]) begin
            r.tx_ius[c] = 1'b1;
            if (en) begin
                r.ipend[pend_bit(a, 1'b0)] = 1'b1;
            end
            r.vec = vec_code(SRC_TX, a, hi);
        end
        return r;
    endfunction

    function automatic irq_state_t drop_rx(input irq_state_t s, input int c,
                                           input logic hi, input logic en);
        irq_state_t r;
        logic       a;
        r = s;
        a = (c == CH_A);
        r.rx_pend[c] = 1'b0;
        r.rx_ius[c]  = 1'b0;
        r.ipend[pend_bit(a, 1'b1)] = 1'b0;
        r.vec = vec_code(SRC_NONE, a, hi);
        if (r.tx_pend[c]) begin
            r = raise_tx(r, c, hi, en);
        end
        return r;
    endfunction

    function automatic irq_state_t drop_tx(input irq_state_t s, input int c, input logic hi);
        irq_state_t r;
        logic       a;
        r = s;
        a = (c == CH_A);
        r.tx_pend[c] = 1'b0;
        r.tx_ius[c]  = 1'b0;
        r.ipend[pend_bit(a, 1'b0)] = 1'b0;
        r.vec = vec_code(SRC_NONE, a, hi);
        if (r.rx_pend[c]) begin
            r = raise_rx(r, c, hi);
        end
        return r;
    endfunction

    function automatic irq_state_t release_ius(input irq_state_t s, input int c,
                                               input logic hi, input logic en);
        irq_state_t r;
        r = s;
        if (r.rx_ius[c]) begin
            r.rx_ius[c] = 1'b0;
            if (r.tx_pend[c]) begin
                r = raise_tx(r, c, hi, en);
            end
        end else if (r.tx_ius[c]) begin
            r.tx_ius[c] = 1'b0;
        end
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (data_rd[c]) st_d = drop_rx(st_d, c, status_hi, tx_int_en[c]);
            if (clr_tx[c])  st_d = drop_tx(st_d, c, status_hi);
            if (clr_ius[c]) st_d = release_ius(st_d, c, status_hi, tx_int_en[c]);
            if (rx_ev[c])   st_d = raise_rx(st_d, c, status_hi);
            if (tx_ev[c])   st_d = raise_tx(st_d, c, status_hi, tx_int_en[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.vec     <= vec_code(SRC_NONE, 1'b0, status_hi);
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_pend  = st_q.rx_pend;
    assign tx_pend  = st_q.tx_pend;
    assign int_pend = st_q.ipend;
    assign vector   = st_q.vec;

    // R1
    reset_vec_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vector == vec_code(SRC_NONE, 1'b0, $past(status_hi)) && int_pend == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2
        rx_sets_ius_chk: assert property (@(posedge clk) disable iff (rst)
            rx_ev[c] |=> (st_q.rx_ius[c] && st_q.rx_pend[c]));

        // R4
        tx_blocked_chk: assert property (@(posedge clk) disable iff (rst)
            (tx_ev == NCH'(1 << c) && st_q.rx_ius[c] &&
             (rx_ev | data_rd | clr_tx | clr_ius) == '0)
            |=> ($stable(vector) && $stable(int_pend) && st_q.tx_pend[c]));

        // R6
        rd_clears_rx_chk: assert property (@(posedge clk) disable iff (rst)
            (data_rd[c] && !rx_ev[c]) |=> !st_q.rx_pend[c]);

        // R7
        clr_tx_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_tx[c] && !tx_ev[c]) |=> !st_q.tx_pend[c]);
    end

endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
    import sio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  status_hi,
    input  logic [NCH-1:0]        tx_int_en,
    input  logic [NCH*MODE_W-1:0] rx_mode,
    input  logic [NCH-1:0]        brk_int_en,
    input  logic [NCH-1:0]        brk_stat,
    input  logic [NCH-1:0]        rx_char_ev,
    input  logic [NCH-1:0]        tx_empty_ev,
    input  logic [NCH-1:0]        data_rd,
    input  logic [NCH-1:0]        clr_tx_cmd,
    input  logic [NCH-1:0]        clr_ius_cmd,
    output logic                  irq,
    output logic [PEND_W-1:0]     int_pend,
    output logic [VEC_W-1:0]      vector
);
    logic [NCH-1:0] rx_pend_w;
    logic [NCH-1:0] tx_pend_w;
    logic [NCH-1:0] chan_req;

    sio_irq_core i_core (
        .clk       (clk),
        .rst       (rst),
        .status_hi (status_hi),
        .tx_int_en (tx_int_en),
        .rx_ev     (rx_char_ev),
        .tx_ev     (tx_empty_ev),
        .data_rd   (data_rd),
        .clr_tx    (clr_tx_cmd),
        .clr_ius   (clr_ius_cmd),
        .rx_pend   (rx_pend_w),
        .tx_pend   (tx_pend_w),
        .int_pend  (int_pend),
        .vector    (vector)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sio_irq_cond #(.MODE_W(MODE_W)) i_cond (
            .tx_en    (tx_int_en[c]),
            .tx_pend  (tx_pend_w[c]),
            .rx_mode  (rx_mode[c*MODE_W +: MODE_W]),
            .rx_pend  (rx_pend_w[c]),
            .brk_en   (brk_int_en[c]),
            .brk_stat (brk_stat[c]),
            .req      (chan_req[c])
        );
    end

    assign irq = |chan_req;

    // R9
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_pend_w == '0 && tx_pend_w == '0 && brk_stat == '0) |-> !irq);

    // R8
    tx_req_chk: assert property (@(posedge clk) disable iff (rst)
        ((tx_pend_w & tx_int_en) != '0) |-> irq);

endmodule

// File: tb/test_sio_irq_vector.sv
module test_sio_irq_vector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       status_hi = 1'b0;
    logic [1:0] tx_int_en = '0;
    logic [3:0] rx_mode = '0;
    logic [1:0] brk_int_en = '0;
    logic [1:0] brk_stat = '0;
    logic [1:0] rx_char_ev = '0;
    logic [1:0] tx_empty_ev = '0;
    logic [1:0] data_rd = '0;
    logic [1:0] clr_tx_cmd = '0;
    logic [1:0] clr_ius_cmd = '0;
    logic       irq;
    logic [5:0] int_pend;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sio_irq_vector i_sio_irq_vector (
        .clk(clk), .rst(rst), .status_hi(status_hi), .tx_int_en(tx_int_en),
        .rx_mode(rx_mode), .brk_int_en(brk_int_en), .brk_stat(brk_stat),
        .rx_char_ev(rx_char_ev), .tx_empty_ev(tx_empty_ev), .data_rd(data_rd),
        .clr_tx_cmd(clr_tx_cmd), .clr_ius_cmd(clr_ius_cmd),
        .irq(irq), .int_pend(int_pend), .vector(vector)
    );

    // kind: 0 none, 1 transmit, 2 receive
    function automatic logic [7:0] exp_code(input int kind, input int is_a, input int hi);
        int rxb;
        if (kind == 0) return (hi != 0) ? 8'h60 : 8'h06;
        rxb = (kind == 2) ? 1 : 0;
        if (hi != 0) return 8'((is_a << 4) | (rxb << 5));
        return 8'((is_a << 3) | (rxb << 2));
    endfunction

    function automatic logic [5:0] pbit(input int is_a, input int is_rx);
        return 6'(1 << ((is_a != 0 ? 3 : 0) + (is_rx != 0 ? 2 : 1)));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // 0 rx, 1 tx, 2 data read, 3 clear tx, 4 clear ius
    task automatic pulse(input int kind, input int ch);
        case (kind)
            0: rx_char_ev[ch]  = 1'b1;
            1: tx_empty_ev[ch] = 1'b1;
            2: data_rd[ch]     = 1'b1;
            3: clr_tx_cmd[ch]  = 1'b1;
            default: clr_ius_cmd[ch] = 1'b1;
        endcase
        @(negedge clk);
        rx_char_ev = '0; tx_empty_ev = '0; data_rd = '0;
        clr_tx_cmd = '0; clr_ius_cmd = '0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int hi = 0; hi < 2; hi++) begin
            for (int te = 0; te < 2; te++) begin
                for (int ch = 0; ch < 2; ch++) begin
                    logic [5:0] rxb, txb, txe;
                    int isa;
                    isa = (ch == 0) ? 1 : 0;
                    rxb = pbit(isa, 1);
                    txb = pbit(isa, 0);
                    txe = (te != 0) ? txb : 6'd0;
                    status_hi = hi[0];
                    tx_int_en = '0;
                    rx_mode = 4'b0101;
                    do_reset();
                    check("R1 vector", vector, exp_code(0, isa, hi));
                    check("R1 int_pend", {2'b0, int_pend}, 8'h00);
                    check("R1 irq", {7'b0, irq}, 8'h00);
                    tx_int_en[ch] = te[0];
                    pulse(0, ch);
                    check("R2 rx vector", vector, exp_code(2, isa, hi));
                    check("R2 rx pend", {2'b0, int_pend}, {2'b0, rxb});
                    check("R9 irq from one channel", {7'b0, irq}, 8'h01);
                    pulse(1, ch);
                    check("R4 vector held", vector, exp_code(2, isa, hi));
                    check("R4 pend held", {2'b0, int_pend}, {2'b0, rxb});
                    pulse(4, ch);
                    check("R5 tx vectored", vector, exp_code(1, isa, hi));
                    check("R5 pend", {2'b0, int_pend}, {2'b0, rxb | txe});
                    pulse(2, ch);
                    check("R6 tx reraised", vector, exp_code(1, isa, hi));
                    check("R6 pend", {2'b0, int_pend}, {2'b0, txe});
                    check("R8 tx enable", {7'b0, irq}, {7'b0, te[0]});
                    pulse(0, ch);
                    check("R2 rx again", vector, exp_code(2, isa, hi));
                    pulse(3, ch);
                    check("R7 rx reraised", vector, exp_code(2, isa, hi));
                    check("R7 pend", {2'b0, int_pend}, {2'b0, rxb});
                    pulse(2, ch);
                    check("R6 idle vector", vector, exp_code(0, isa, hi));
                    check("R6 idle pend", {2'b0, int_pend}, 8'h00);
                    check("R6 idle irq", {7'b0, irq}, 8'h00);
                    pulse(1, ch);
                    check("R3 tx vector", vector, exp_code(1, isa, hi));
                    check("R3 tx pend", {2'b0, int_pend}, {2'b0, txe});
                    check("R8 tx irq", {7'b0, irq}, {7'b0, te[0]});
                    pulse(4, ch);
                    check("R5 tx ius clear vector", vector, exp_code(1, isa, hi));
                    check("R5 tx ius clear pend", {2'b0, int_pend}, {2'b0, txe});
                    pulse(3, ch);
                    check("R7 idle vector", vector, exp_code(0, isa, hi));
                    check("R7 idle pend", {2'b0, int_pend}, 8'h00);
                end
            end
        end

        status_hi = 1'b0;
        tx_int_en = '0;
        for (int m = 0; m < 4; m++) begin
            rx_mode = 4'(m << 2);
            do_reset();
            pulse(0, 1);
            check("R8 rx mode", {7'b0, irq}, {7'b0, (m == 1 || m == 2)});
        end

        rx_mode = '0;
        do_reset();
        brk_stat = 2'b10;
        brk_int_en = 2'b00;
        @(negedge clk);
        check("R8 break disabled", {7'b0, irq}, 8'h00);
        brk_int_en = 2'b10;
        @(negedge clk);
        check("R9 break on channel B", {7'b0, irq}, 8'h01);
        brk_stat = 2'b01;
        @(negedge clk);
        check("R8 break enable mismatch", {7'b0, irq}, 8'h00);
        brk_stat = '0;
        brk_int_en = '0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule